// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block takes one operand request from a core and carries it out as a series of cycles on a 16-bit external data bus. The operand can be 1, 2, 3 or 4 bytes long. In each cycle the responding device returns a two-bit active-low acknowledge. That code either holds the cycle open or ends it, and when it ends the cycle it also reports whether the port is 8 or 16 bits wide. The block learns the width again in every cycle. Each cycle moves as many bytes as that width allows. Bytes move most significant first. After each cycle the bus address steps forward by the number of bytes that cycle moved.

On a read, the received bytes are shifted into a result register, so the operand ends up right-justified in 32 bits. On a write, the next unsent bytes of the operand are placed on fixed data lanes. The top byte lane (bits 15:8) always carries the next byte. The low byte lane (bits 7:0) carries the byte after it whenever two or more bytes remain. The block drops its strobe for one clock between the cycles of one operand. The requester sees a one-clock done pulse with the result. A reserved acknowledge code ends the operand early with an error pulse.

Top module: `dyn_bus_sizer`

## Requirements
- R1: After reset `bus_strobe`, `done`, `err` and `busy` are all low.
- R2: The first cycle of an operand drives `bus_addr` equal to the request address. On a write it assumes a 16-bit port: the first operand byte (the most significant) goes on `bus_dout[15:8]`, and the second byte goes on `bus_dout[7:0]` when the operand has two or more bytes. `bus_write` follows the request's write flag while the strobe is high.
- R3: While the strobe is high and `ack_n` = 2'b11, the cycle stays open with `bus_addr` and `bus_dout` unchanged.
- R4: `ack_n` = 2'b01 (bit 1 low, bit 0 high) ends the cycle as a 16-bit port. With two or more bytes left, two bytes move: `bus_din[15:8]` is the earlier byte, `bus_din[7:0]` is the later byte, and the address steps by 2. A long word on a 16-bit port takes two cycles.
- R5: `ack_n` = 2'b10 (bit 1 high, bit 0 low) ends the cycle as an 8-bit port. One byte moves, taken from `bus_din[15:8]` only, and the address steps by 1. A long word on an 8-bit port takes four cycles.
- R6: When a 16-bit acknowledge ends a cycle that had one byte left, only `bus_din[15:8]` is captured and the operand ends.
- R7: After the final acknowledge, `done` is high for exactly one clock. On a read, `rdata` holds the operand right-justified, most significant byte first, with the unused upper bytes zero. The strobe is low while `done` is high.
- R8: `ack_n` = 2'b00 during a cycle ends the operand. `done` and `err` are both high in the next clock, and no further bus cycle is started.
- R9: After each completed cycle of a write, the next cycle presents the next unsent byte on `bus_dout[15:8]`, and the one after it on `bus_dout[7:0]` if at least two bytes remain.
- R10: `req_size` encodes the operand length: 0 = byte, 1 = word, 2 = three bytes, 3 = long word.
- R11: Between two cycles of one operand, the strobe is low for exactly one clock. A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an operand when the block is idle |
| req_size | input | 2 | Operand length code |
| req_addr | input | AW | Operand start address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, right-justified |
| busy | output | 1 | Operand in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Reserved acknowledge seen; valid with done |
| rdata | output | 32 | Assembled read operand, right-justified |
| bus_strobe | output | 1 | Bus cycle active |
| bus_write | output | 1 | Direction of the active cycle |
| bus_addr | output | AW | Byte address of the current cycle |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| ack_n | input | 2 | Active-low data-size acknowledge code |

## Verification
Every operand length is run against an all-16-bit port, an all-8-bit port and a port whose width changes from cycle to cycle. This separates per-cycle width learning from a width decided once per operand. Reads use a device pattern that depends on the address and puts a distinct byte on the low lane. A read that captured the low lane when only one byte was left would therefore return a wrong result. Writes use operands whose bytes are all different, so a swapped lane or a skipped byte changes the observed lane values. Wait states, an address that carries across a 16-bit boundary, a reserved acknowledge and a request raised while busy are each tried in directed tests.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int OP_BYTES = 4;
  localparam int OP_W     = 8 * OP_BYTES;
  localparam int LANE_W   = 16;
  localparam int CNT_W    = $clog2(OP_BYTES + 1);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_TRI  = 2'd2,
    SZ_LONG = 2'd3
  } op_size_t;

  typedef enum logic [1:0] {
    ACK_WAIT,
    ACK_PORT8,
    ACK_PORT16,
    ACK_RESV
  } ack_kind_t;
endpackage

// File: rtl/bsz_ack_decode.sv
module bsz_ack_decode
  import bsz_pkg::*;
(
  input  logic [1:0] ack_n,
  output ack_kind_t  kind
);
  always_comb begin
    unique case (ack_n)
      2'b11:   kind = ACK_WAIT;
      2'b10:   kind = ACK_PORT8;
      2'b01:   kind = ACK_PORT16;
      default: kind = ACK_RESV;
    endcase
  end
endmodule

// File: rtl/bsz_datapath.sv
module bsz_datapath
  import bsz_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  op_size_t          size_in,
  input  logic [AW-1:0]     addr_in,
  input  logic              write_in,
  input  logic [OP_W-1:0]   wdata_in,
  input  logic              step,
  input  logic              wide,
  input  logic [LANE_W-1:0] din,
  output logic [AW-1:0]     addr,
  output logic [LANE_W-1:0] dout,
  output logic              wr,
  output logic [OP_W-1:0]   rdata,
  output logic              last
);
  logic [AW-1:0]    addr_q, addr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, moved;
  logic [OP_W-1:0]  wbuf_q, wbuf_d, rbuf_q, rbuf_d;
  logic             wr_q, wr_d;
  logic             multi, take2;

  always_comb begin
    multi  = cnt_q > CNT_W'(1);
    take2  = wide && multi;
    moved  = take2 ? CNT_W'(2) : CNT_W'(1);
    last   = (cnt_q == moved);
    addr_d = addr_q;
    cnt_d  = cnt_q;
    wbuf_d = wbuf_q;
    rbuf_d = rbuf_q;
    wr_d   = wr_q;
    if (load) begin
      addr_d = addr_in;
      wr_d   = write_in;
      rbuf_d = '0;
      unique case (size_in)
        SZ_BYTE: begin cnt_d = CNT_W'(1); wbuf_d = {wdata_in[7:0],  24'h0}; end
        SZ_WORD: begin cnt_d = CNT_W'(2); wbuf_d = {wdata_in[15:0], 16'h0}; end
        SZ_TRI:  begin cnt_d = CNT_W'(3); wbuf_d = {wdata_in[23:0], 8'h0};  end
        default: begin cnt_d = CNT_W'(4); wbuf_d = wdata_in;                end
      endcase
    end else if (step) begin
      addr_d = addr_q + AW'(moved);
      cnt_d  = cnt_q - moved;
      if (take2) begin
        wbuf_d = {wbuf_q[OP_W-17:0], 16'h0};
        rbuf_d = {rbuf_q[OP_W-17:0], din};
      end else begin
        wbuf_d = {wbuf_q[OP_W-9:0], 8'h0};
        rbuf_d = {rbuf_q[OP_W-9:0], din[15:8]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      wbuf_q <= '0;
      rbuf_q <= '0;
      wr_q   <= 1'b0;
    end else if (load || step) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      wbuf_q <= wbuf_d;
      rbuf_q <= rbuf_d;
      wr_q   <= wr_d;
    end
  end

  assign addr  = addr_q;
  assign dout  = {wbuf_q[OP_W-1:OP_W-8], multi ? wbuf_q[OP_W-9:OP_W-16] : 8'h00};
  assign wr    = wr_q;
  assign rdata = rbuf_q;

  // R4
  step_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && wide && cnt_q > CNT_W'(1)) |=> (addr_q == $past(addr_q) + AW'(2)));
  // R5
  step_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !wide) |=> (addr_q == $past(addr_q) + AW'(1)));
endmodule

// File: rtl/bsz_ctrl.sv
module bsz_ctrl
  import bsz_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  ack_kind_t kind,
  input  logic      last,
  output logic      load,
  output logic      step,
  output logic      strobe,
  output logic      busy,
  output logic      done,
  output logic      err
);
  typedef enum logic [1:0] { S_IDLE, S_RUN, S_GAP } state_t;

  state_t state_q, state_d;
  logic   done_q, done_d, err_q, err_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        load    = 1'b1;
        state_d = S_RUN;
      end
      S_RUN: begin
        unique case (kind)
          ACK_PORT8, ACK_PORT16: begin
            step = 1'b1;
            if (last) begin
              done_d  = 1'b1;
              state_d = S_IDLE;
            end else begin
              state_d = S_GAP;
            end
          end
          ACK_RESV: begin
            done_d  = 1'b1;
            err_d   = 1'b1;
            state_d = S_IDLE;
          end
          default: state_d = S_RUN;
        endcase
      end
      default: state_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign strobe = (state_q == S_RUN);
  assign busy   = (state_q != S_IDLE);
  assign done   = done_q;
  assign err    = err_q;

  // R8
  resv_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && kind == ACK_RESV) |=> (done && err && !strobe));
  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !strobe);
  // R11
  gap_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> (!strobe ##1 strobe));
endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
  import bsz_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [31:0]   rdata,
  output logic          bus_strobe,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_dout,
  input  logic [15:0]   bus_din,
  input  logic [1:0]    ack_n
);
  ack_kind_t kind;
  logic      load, step, last, wr;

  bsz_ack_decode u_dec (
    .ack_n (ack_n),
    .kind  (kind)
  );

  bsz_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .kind      (kind),
    .last      (last),
    .load      (load),
    .step      (step),
    .strobe    (bus_strobe),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  bsz_datapath #(.AW(AW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .size_in  (op_size_t'(req_size)),
    .addr_in  (req_addr),
    .write_in (req_write),
    .wdata_in (req_wdata),
    .step     (step),
    .wide     (kind == ACK_PORT16),
    .din      (bus_din),
    .addr     (bus_addr),
    .dout     (bus_dout),
    .wr       (wr),
    .rdata    (rdata),
    .last     (last)
  );

  assign bus_write = wr && bus_strobe;

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && ack_n == 2'b11) |=> (bus_strobe && $stable(bus_addr) && $stable(bus_dout)));
endmodule

// File: tb/sim_dyn_bus_sizer.sv
`timescale 1ns/1ps
module sim_dyn_bus_sizer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, err, bus_strobe, bus_write;
  logic [31:0] rdata;
  logic [23:0] bus_addr;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;
  logic [1:0]  ack_n = 2'b11;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dyn_bus_sizer #(.AW(24)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .bus_strobe(bus_strobe), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_din(bus_din), .ack_n(ack_n)
  );

  typedef struct packed {
    logic [1:0]  sz;
    logic [23:0] addr;
    logic        wr;
    logic [31:0] wd;
    logic [3:0]  p16;
    logic [1:0]  waits;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{2'd3, 24'h001000, 1'b0, 32'h0,        4'b1111, 2'd0},
    '{2'd3, 24'h002004, 1'b0, 32'h0,        4'b0000, 2'd1},
    '{2'd1, 24'h0030F0, 1'b0, 32'h0,        4'b0000, 2'd0},
    '{2'd0, 24'h004011, 1'b0, 32'h0,        4'b1111, 2'd0},
    '{2'd2, 24'h005020, 1'b0, 32'h0,        4'b1111, 2'd2},
    '{2'd3, 24'h006000, 1'b1, 32'h11223344, 4'b0000, 2'd0},
    '{2'd2, 24'h007002, 1'b1, 32'h00AABBCC, 4'b1111, 2'd1},
    '{2'd1, 24'h0080FE, 1'b1, 32'h0000BEEF, 4'b1111, 2'd0},
    '{2'd2, 24'h00FFFF, 1'b0, 32'h0,        4'b0000, 2'd0},
    '{2'd3, 24'h009100, 1'b0, 32'h0,        4'b0110, 2'd0},
    '{2'd3, 24'h00A200, 1'b1, 32'hCAFE5A71, 4'b1001, 2'd0}
  };

  function automatic logic [7:0] dev_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v, input bit poke);
    int          n;
    int          pos;
    int          k;
    int          rem;
    logic [31:0] exp;
    logic [23:0] a;
    bit          w;
    n   = int'(v.sz) + 1;
    exp = '0;
    for (int i = 0; i < n; i++) exp = (exp << 8) | 32'(dev_byte(v.addr + 24'(i)));
    @(negedge clk);
    req_valid = 1'b1; req_size = v.sz; req_addr = v.addr;
    req_write = v.wr; req_wdata = v.wd;
    @(negedge clk);
    req_valid = 1'b0;
    pos = 0; k = 0;
    while (pos < n) begin
      a   = v.addr + 24'(pos);
      rem = n - pos;
      chk(bus_strobe && busy, "R2 strobe up", 32'(bus_strobe), 1);
      chk(bus_addr == a, "R2/R4/R5 cycle address", 32'(bus_addr), 32'(a));
      chk(bus_write == v.wr, "R2 direction", 32'(bus_write), 32'(v.wr));
      if (v.wr) begin
        chk(bus_dout[15:8] == v.wd[8*(n-1-pos) +: 8], "R2/R9 upper lane",
            32'(bus_dout[15:8]), 32'(v.wd[8*(n-1-pos) +: 8]));
        if (rem >= 2)
          chk(bus_dout[7:0] == v.wd[8*(n-2-pos) +: 8], "R2/R9 lower lane",
              32'(bus_dout[7:0]), 32'(v.wd[8*(n-2-pos) +: 8]));
      end
      if (k == 0) begin
        for (int j = 0; j < int'(v.waits); j++) begin
          ack_n = 2'b11;
          @(negedge clk);
          chk(bus_strobe && bus_addr == a, "R3 wait holds", 32'(bus_addr), 32'(a));
          if (v.wr)
            chk(bus_dout[15:8] == v.wd[8*(n-1) +: 8], "R3 data holds",
                32'(bus_dout[15:8]), 32'(v.wd[8*(n-1) +: 8]));
        end
      end
      if (poke && k == 0) begin
        req_valid = 1'b1; req_addr = 24'h0ABCDE; req_size = 2'd0;
      end
      w = v.p16[k];
      ack_n   = w ? 2'b01 : 2'b10;
      bus_din = w ? {dev_byte(a), dev_byte(a + 24'd1)} : {dev_byte(a), 8'h3C};
      @(negedge clk);
      ack_n = 2'b11; req_valid = 1'b0;
      pos = pos + ((w && rem >= 2) ? 2 : 1);
      k++;
      if (pos < n) begin
        chk(!bus_strobe && !done, "R11 gap between cycles", 32'(bus_strobe), 0);
        @(negedge clk);
      end
    end
    chk(done && !err, "R7 done pulse", {30'd0, done, err}, 32'd2);
    chk(!bus_strobe, "R7 strobe low at done", 32'(bus_strobe), 0);
    if (!v.wr) chk(rdata == exp, "R6/R7/R10 read result", rdata, exp);
    @(negedge clk);
    chk(!done && !bus_strobe, "R7/R11 single pulse, no extra cycle", {30'd0, done, bus_strobe}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_strobe && !done && !err && !busy, "R1 reset state",
        {28'd0, bus_strobe, done, err, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_strobe && !busy, "R1 idle after release", {30'd0, bus_strobe, busy}, 0);

    for (int i = 0; i < NV; i++) run_op(VT[i], 1'b0);

    // R11: request raised while busy is ignored
    run_op('{2'd3, 24'h00B300, 1'b0, 32'h0, 4'b0000, 2'd0}, 1'b1);
    @(negedge clk);
    chk(!bus_strobe && !busy, "R11 busy request dropped", {30'd0, bus_strobe, busy}, 0);

    // R8: reserved acknowledge aborts
    @(negedge clk);
    req_valid = 1'b1; req_size = 2'd3; req_addr = 24'h00C400; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_strobe, "R8 cycle started", 32'(bus_strobe), 1);
    ack_n = 2'b00;
    @(negedge clk);
    ack_n = 2'b11;
    chk(done && err && !bus_strobe, "R8 abort flags", {29'd0, done, err, bus_strobe}, 32'd6);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(!bus_strobe && !done && !err && !busy, "R8 no further cycle",
          {28'd0, bus_strobe, done, err, busy}, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule